// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits in front of the page-write engine of a byte-wide non-volatile memory and screens every incoming byte write (address plus data). It holds a protect flag and watches the write stream for two command sequences. The first is a three-write arming prefix. The second is a six-write release code. For each write it decides, in the same cycle, whether that write may pass on to the page buffer.

While the flag is clear, ordinary writes pass freely. While the flag is set, a write passes only when it directly follows the three-write prefix. The flag becomes set only when a real data write follows the prefix; the prefix on its own leaves the flag unchanged. The release code clears the flag. Command bytes that the detector takes in are never forwarded, so none of the bytes in the release code reach the array.

A write that breaks a sequence part-way returns the detector to its idle state. That write is then judged as an ordinary write against the current flag.

Top module: `sdp_guard`

## Requirements
- R1: In the cycle after synchronous reset is released, `prot_on` equals the parameter `PROT_INIT` (default 0), and the detector is idle.
- R2: While `prot_on` is 0, a write whose address is neither 0x5555 nor 0x2AAA gets `wr_permit` = 1 in the cycle it is presented.
- R3: A write that matches the next expected step of a command sequence is consumed and gets `wr_permit` = 0. The steps are: 0xAA at 0x5555, then 0x55 at 0x2AAA, then either 0xA0 at 0x5555 (arm) or 0x80 at 0x5555 (release path).
- R4: The first write after the arm step is a data write. It gets `wr_permit` = 1 whatever its address, its data and the flag, and `prot_on` reads 1 from the next cycle on.
- R5: The three-write prefix with no following write leaves `prot_on` unchanged.
- R6: While `prot_on` is 1, a write that neither matches an expected command step nor follows a completed prefix gets `wr_permit` = 0.
- R7: The release code has six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. All six get `wr_permit` = 0, and `prot_on` reads 0 from the cycle after the sixth.
- R8: A write that mismatches part-way through a sequence returns the detector to idle. That write gets `wr_permit` equal to NOT `prot_on`, and the following write is judged from idle.
- R9: When `wr_valid` is 0, `wr_permit` is 0 and neither the detector state nor `prot_on` changes.
- R10: While `prot_on` is 1, a write that follows a fresh prefix is permitted, and `prot_on` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A byte write is presented this cycle |
| wr_addr | input | 15 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| wr_permit | output | 1 | The presented write may go to the page buffer (combinational) |
| prot_on | output | 1 | Current protect flag |

## Verification
Two of the block's functions can land on the same write. The first case is the data write that completes arming: it can itself look like the first byte of a new sequence, for example 0xAA at 0x5555 directly after the arm step. The second case is a sequence mismatch, which must both reset the detector and be judged as ordinary data. The bench drives both on purpose, using directed cases and a random stream biased toward the command addresses and bytes. A bench model, written from the requirements, predicts the expected permit and flag for each write; in the first case it expects the data role to win and the write to be permitted.

// File: rtl/sdp_guard_pkg.sv
package sdp_guard_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;
    localparam int N_PAT  = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } wr_t;

    localparam addr_t KEY_ADR_HI = 15'h5555;
    localparam addr_t KEY_ADR_LO = 15'h2AAA;

    // indices into the pattern hit vector
    localparam int P_KEY1 = 0;   // AA @ 5555
    localparam int P_KEY2 = 1;   // 55 @ 2AAA
    localparam int P_ARM  = 2;   // A0 @ 5555
    localparam int P_OFF  = 3;   // 80 @ 5555
    localparam int P_FIN  = 4;   // 20 @ 5555

    typedef logic [N_PAT-1:0] hit_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_ARMED,
        ST_R1,
        ST_R2,
        ST_R3
    } st_e;

    typedef struct packed {
        logic permit;
        logic set_prot;
        logic clr_prot;
    } act_t;

    function automatic wr_t pat_of(input int idx);
        wr_t p;
        case (idx)
            P_KEY1:  p = '{addr: KEY_ADR_HI, data: 8'hAA};
            P_KEY2:  p = '{addr: KEY_ADR_LO, data: 8'h55};
            P_ARM:   p = '{addr: KEY_ADR_HI, data: 8'hA0};
            P_OFF:   p = '{addr: KEY_ADR_HI, data: 8'h80};
            default: p = '{addr: KEY_ADR_HI, data: 8'h20};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sdp_match.sv
module sdp_match
    import sdp_guard_pkg::*;
(
    input  logic valid,
    input  wr_t  wr,
    output hit_t hit
);

    for (genvar g = 0; g < N_PAT; g++) begin : g_pat
        localparam wr_t PAT = pat_of(g);
        assign hit[g] = valid && (wr == PAT);
    end

endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
    import sdp_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  hit_t hit,
    input  logic prot,
    output act_t act
);

    st_e st_q, st_d;

    always_comb begin
        st_d         = st_q;
        act.permit   = 1'b0;
        act.set_prot = 1'b0;
        act.clr_prot = 1'b0;
        if (valid) begin
            // default: mismatch or plain data, judged against the flag
            st_d       = ST_IDLE;
            act.permit = !prot;
            case (st_q)
                ST_IDLE: if (hit[P_KEY1]) begin st_d = ST_K1; act.permit = 1'b0; end
                ST_K1:   if (hit[P_KEY2]) begin st_d = ST_K2; act.permit = 1'b0; end
                ST_K2: begin
                    if (hit[P_ARM]) begin
                        st_d = ST_ARMED; act.permit = 1'b0;
                    end else if (hit[P_OFF]) begin
                        st_d = ST_R1; act.permit = 1'b0;
                    end
                end
                ST_ARMED: begin
                    act.permit   = 1'b1;
                    act.set_prot = 1'b1;
                end
                ST_R1:   if (hit[P_KEY1]) begin st_d = ST_R2; act.permit = 1'b0; end
                ST_R2:   if (hit[P_KEY2]) begin st_d = ST_R3; act.permit = 1'b0; end
                ST_R3: begin
                    if (hit[P_FIN]) begin
                        act.permit   = 1'b0;
                        act.clr_prot = 1'b1;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/sdp_prot_flag.sv
module sdp_prot_flag #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic prot_o
);

    always_ff @(posedge clk) begin
        if (rst)        prot_o <= INIT;
        else if (set_i) prot_o <= 1'b1;
        else if (clr_i) prot_o <= 1'b0;
    end

endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
    import sdp_guard_pkg::*;
#(
    parameter logic PROT_INIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_permit,
    output logic              prot_on
);

    wr_t  wr;
    hit_t hit;
    act_t act;

    assign wr = '{addr: wr_addr, data: wr_data};

    sdp_match u_match (
        .valid (wr_valid),
        .wr    (wr),
        .hit   (hit)
    );

    sdp_seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .valid (wr_valid),
        .hit   (hit),
        .prot  (prot_on),
        .act   (act)
    );

    sdp_prot_flag #(.INIT(PROT_INIT)) u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (act.set_prot),
        .clr_i  (act.clr_prot),
        .prot_o (prot_on)
    );

    assign wr_permit = act.permit;

endmodule

// File: rtl/sdp_guard_chk.sv
module sdp_guard_chk
    import sdp_guard_pkg::*;
#(
    parameter logic PROT_INIT = 1'b0
) (
    input logic  clk,
    input logic  rst,
    input logic  wr_valid,
    input addr_t wr_addr,
    input data_t wr_data,
    input logic  wr_permit,
    input logic  prot_on
);

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prot_on == PROT_INIT));

    assert_plain_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (!prot_on && wr_valid && wr_addr != KEY_ADR_HI && wr_addr != KEY_ADR_LO)
        |-> wr_permit);

    assert_arm_by_data_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_on) |-> $past(wr_valid && wr_permit));

    assert_release_code_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_on) |-> $past(wr_valid && !wr_permit &&
                                 wr_addr == KEY_ADR_HI && wr_data == 8'h20));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> (!wr_permit ##1 $stable(prot_on)));

    assert_keep_prot_R10: assert property (@(posedge clk) disable iff (rst)
        (prot_on && wr_valid && wr_permit) |=> prot_on);

endmodule

bind sdp_guard sdp_guard_chk #(.PROT_INIT(PROT_INIT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_permit (wr_permit),
    .prot_on   (prot_on)
);

// File: tb/sdp_guard_tb_top.sv
`timescale 1ns/1ps
module sdp_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_permit;
    logic        prot_on;

    int n_chk = 0;
    int n_err = 0;
    int m_pos = 0;
    logic m_prot = 1'b0;

    always #2.5 clk = ~clk;

    sdp_guard dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_permit (wr_permit),
        .prot_on   (prot_on)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(input logic [14:0] a, input logic [7:0] d, output logic perm);
        bit k1  = (a == 15'h5555 && d == 8'hAA);
        bit k2  = (a == 15'h2AAA && d == 8'h55);
        bit arm = (a == 15'h5555 && d == 8'hA0);
        bit off = (a == 15'h5555 && d == 8'h80);
        bit fin = (a == 15'h5555 && d == 8'h20);
        perm = !m_prot;
        case (m_pos)
            0: if (k1) begin m_pos = 1; perm = 1'b0; end
            1: if (k2) begin m_pos = 2; perm = 1'b0; end else m_pos = 0;
            2: if (arm) begin m_pos = 3; perm = 1'b0; end
               else if (off) begin m_pos = 4; perm = 1'b0; end
               else m_pos = 0;
            3: begin perm = 1'b1; m_prot = 1'b1; m_pos = 0; end
            4: if (k1) begin m_pos = 5; perm = 1'b0; end else m_pos = 0;
            5: if (k2) begin m_pos = 6; perm = 1'b0; end else m_pos = 0;
            default: begin
                if (fin) begin perm = 1'b0; m_prot = 1'b0; end
                m_pos = 0;
            end
        endcase
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d, input string tag);
        logic ep;
        model(a, d, ep);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #1;
        chk({tag, " permit"}, wr_permit, ep);
        @(posedge clk);
        #1;
        chk({tag, " prot"}, prot_on, m_prot);
    endtask

    task automatic idle(input int n, input logic [14:0] a, input logic [7:0] d);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid = 1'b0; wr_addr = a; wr_data = d;
            #1;
            chk("R9 permit idle", wr_permit, 1'b0);
            @(posedge clk);
            #1;
            chk("R9 prot idle", prot_on, m_prot);
        end
    endtask

    task automatic prefix(input string tag);
        wr(15'h5555, 8'hAA, tag);
        wr(15'h2AAA, 8'h55, tag);
        wr(15'h5555, 8'hA0, tag);
    endtask

    task automatic release_code(input string tag);
        wr(15'h5555, 8'hAA, tag);
        wr(15'h2AAA, 8'h55, tag);
        wr(15'h5555, 8'h80, tag);
        wr(15'h5555, 8'hAA, tag);
        wr(15'h2AAA, 8'h55, tag);
        wr(15'h5555, 8'h20, tag);
    endtask

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [14:0] a;
        logic [7:0]  d;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 reset prot", prot_on, 1'b0);

        wr(15'h0100, 8'h3C, "R2 plain write");
        wr(15'h7FFF, 8'hAA, "R2 plain write top");
        // R5: prefix alone, then idle
        prefix("R3 prefix step");
        idle(4, 15'h5555, 8'hAA);
        chk("R5 prefix alone", prot_on, 1'b0);
        // R4: arm with data that looks like a command start
        prefix("R3 prefix step");
        wr(15'h5555, 8'hAA, "R4 arm data");
        chk("R4 armed", prot_on, 1'b1);
        wr(15'h0123, 8'h11, "R6 blocked plain");
        wr(15'h2AAA, 8'h55, "R6 blocked cmd-like");
        // R10: protected write with prefix
        prefix("R3 prefix protected");
        wr(15'h0040, 8'h5A, "R10 guarded write");
        chk("R10 still on", prot_on, 1'b1);
        // R8: mismatch while protected
        wr(15'h5555, 8'hAA, "R3 step");
        wr(15'h2AAA, 8'h55, "R3 step");
        wr(15'h5555, 8'h33, "R8 mismatch blocked");
        wr(15'h0040, 8'h77, "R8 from idle blocked");
        // R9: command bytes with valid low
        idle(3, 15'h5555, 8'hA0);
        // R7: release
        release_code("R7 release step");
        chk("R7 released", prot_on, 1'b0);
        // R8: mismatch while clear, passes
        wr(15'h5555, 8'hAA, "R3 step");
        wr(15'h2AAB, 8'h55, "R8 mismatch passes");
        wr(15'h2AAA, 8'h55, "R8 judged from idle");
        // release code while already clear
        release_code("R7 release when clear");

        // random stream biased toward command values
        for (int i = 0; i < 3000; i++) begin
            case ($urandom_range(0, 3))
                0: a = 15'h2AAA;
                1, 2: a = 15'h5555;
                default: a = 15'($urandom);
            endcase
            case ($urandom_range(0, 6))
                0: d = 8'hAA;
                1: d = 8'h55;
                2: d = 8'hA0;
                3: d = 8'h80;
                4: d = 8'h20;
                default: d = 8'($urandom);
            endcase
            if ($urandom_range(0, 40) == 0) prefix("R4 rnd prefix");
            else if ($urandom_range(0, 60) == 0) release_code("R7 rnd release");
            else if ($urandom_range(0, 15) == 0) idle(1, a, d);
            else wr(a, d, "R8 rnd write");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule